// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies a chain of data blocks. Each block is described by a four-word descriptor in memory. Software sets the starting source address, the address of the first descriptor and the handshake mode. It then sets the channel enable bit. While the global enable is on, the channel fetches a descriptor and copies the block it describes. It then follows the next-descriptor pointer until it reaches a zero pointer.

The destination address of every block comes from the descriptor fetched just before that block. The source address goes back to the value software programmed at the start of every block. The source word inside each descriptor is read but has no effect. Data moves word by word through one memory master port, in transactions of a programmable burst length. Each transaction waits for a request from both the source side and the destination side, and ends with an acknowledge pulse to both.

Five interrupt sources are kept as raw status bits, each cleared by writing 1:

- transfer done
- block done
- source transaction
- destination transaction
- error

Each raw bit is gated by a mask bit and by the interrupt-enable bit of the current control word, which gives the masked status and the interrupt line.

Top module: `dma_ll_chan`

## Requirements
- R1: The channel leaves idle only while both the channel enable bit (offset 0x04, bit 0) and the global enable bit (offset 0x00, bit 0) are 1. Its first descriptor read uses the first-descriptor pointer (offset 0x0C).
- R2: A descriptor is four words read at pointer +0, +4, +8 and +12, in this order: source, destination, next pointer, control. The source word has no effect on the copy.
- R3: At the start of every block, the source address is reloaded from the programmed source register (offset 0x08).
- R4: The destination of a block starts at the descriptor's destination word and advances by 4 for each word moved.
- R5: A transaction starts only when the source and destination requests are both active. After each transaction, the source and destination acknowledges each pulse high for exactly one cycle. The source-transaction raw bit and the destination-transaction raw bit are then set.
- R6: The request-select register (offset 0x10) chooses the request for each side: bit 0 for the source, bit 1 for the destination. A 0 selects the hardware request input. A 1 selects a software request bit in offset 0x14 (bit 0 source, bit 1 destination). Writing 1 sets a software request bit, and the bit clears itself when the transaction is acknowledged.
- R7: Control word fields:
  - bits [15:0]: block length in words;
  - bits [23:16]: burst length (0 counts as 1);
  - bit 31: interrupt enable.

  The final transaction of a block is shortened to the words that remain, and no word past the block is written.
- R8: At the end of each block, raw bit 1 is set. The masked status (offset 0x20) equals raw AND mask (offset 0x18) when the control word's interrupt-enable bit is 1, and is 0 otherwise. `irq` is the OR of the masked status bits.
- R9: When a block ends and its next pointer is zero, raw bit 0 is set and the hardware clears the channel enable bit. The enable bit reads back as 0.
- R10: Raw status (offset 0x1C) uses these bit positions: 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error. Writing 1 to a bit at offset 0x24 clears that raw bit and leaves the other bits unchanged.
- R11: An error response from memory, during a descriptor read or a data move, sets raw bit 4 and clears the channel enable bit. The channel then stops, with no further memory writes.
- R12: The memory request holds its address, direction and data stable until the cycle in which `m_done` is seen.
- R13: The source register and the first-descriptor register read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of masked status |
| src_req | input | 1 | Hardware request from the source side |
| dst_req | input | 1 | Hardware request from the destination side |
| src_ack | output | 1 | Transaction acknowledge to the source side |
| dst_ack | output | 1 | Transaction acknowledge to the destination side |
| m_req | output | 1 | Memory access request |
| m_we | output | 1 | Memory access is a write |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_done | input | 1 | Memory access finished this cycle |
| m_err | input | 1 | Error response, valid with m_done |
| m_rdata | input | 32 | Memory read data, valid with m_done |

## Verification
A register write takes effect at the next clock edge. Reads are combinational, so the bench samples them just after the falling edge. In the bench memory model, `m_done` comes one cycle after a request, so each copied word costs a read and a write of two cycles each. Acknowledge pulses last one cycle and are counted at each rising edge. The bench only judges a block's results after it has polled the channel enable bit back to 0, which also covers the completion and error cases. For software requests and a held-off global enable, the bench waits a fixed number of cycles, well beyond one word's time, before checking that nothing moved.

// File: rtl/dmal_pkg.sv
package dmal_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int CNT_W = 16;
    localparam int BL_W  = 8;
    localparam int NIRQ  = 5;

    localparam int IRQ_TFR = 0;
    localparam int IRQ_BLK = 1;
    localparam int IRQ_SRC = 2;
    localparam int IRQ_DST = 3;
    localparam int IRQ_ERR = 4;

    localparam int RG_GCFG  = 0;
    localparam int RG_CHEN  = 1;
    localparam int RG_SRC   = 2;
    localparam int RG_FIRST = 3;
    localparam int RG_CFG   = 4;
    localparam int RG_SWREQ = 5;
    localparam int RG_MASK  = 6;
    localparam int RG_RAW   = 7;
    localparam int RG_STAT  = 8;
    localparam int RG_CLR   = 9;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR, S_ACK, S_BEND
    } seq_st_e;

    typedef struct packed {
        logic             int_en;
        logic [6:0]       rsvd;
        logic [BL_W-1:0]  burst;
        logic [CNT_W-1:0] count;
    } ctl_word_t;

    function automatic logic [CNT_W-1:0] beats_for(input logic [BL_W-1:0] bl,
                                                   input logic [CNT_W-1:0] rem);
        logic [CNT_W-1:0] b;
        b = (bl == '0) ? CNT_W'(1) : CNT_W'(bl);
        return (b < rem) ? b : rem;
    endfunction
endpackage

// File: rtl/dmal_hs.sv
module dmal_hs #(
    parameter int NSIDE = 2
) (
    input  logic [NSIDE-1:0] sel,
    input  logic [NSIDE-1:0] hw,
    input  logic [NSIDE-1:0] sw,
    output logic [NSIDE-1:0] rdy
);
    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        assign rdy[i] = sel[i] ? sw[i] : hw[i];
    end
endmodule

// File: rtl/dmal_regs.sv
module dmal_regs
    import dmal_pkg::*;
#(
    parameter int RA_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NIRQ-1:0] hw_set,
    input  logic            chen_clr,
    input  logic            sw_clr,
    input  logic            int_en,
    output logic            gen,
    output logic            chen,
    output logic [AW-1:0]   src_init,
    output logic [AW-1:0]   first_ptr,
    output logic [1:0]      hs_sel,
    output logic [1:0]      sw_req,
    output logic            irq
);
    localparam int IDX_W = RA_W - 2;

    logic [IDX_W-1:0] widx;
    logic [NIRQ-1:0]  mask_q, raw_q, stat, clr_bits;
    logic [1:0]       sw_nxt;

    assign widx     = reg_addr[RA_W-1:2];
    assign stat     = raw_q & mask_q & {NIRQ{int_en}};
    assign irq      = |stat;
    assign clr_bits = (reg_we && widx == IDX_W'(RG_CLR)) ? reg_wdata[NIRQ-1:0] : '0;
    assign sw_nxt   = (sw_req | ((reg_we && widx == IDX_W'(RG_SWREQ)) ? reg_wdata[1:0] : 2'b00))
                      & ~{2{sw_clr}};

    always_ff @(posedge clk) begin
        if (rst) begin
            gen       <= 1'b0;
            chen      <= 1'b0;
            src_init  <= '0;
            first_ptr <= '0;
            hs_sel    <= '0;
            sw_req    <= '0;
            mask_q    <= '0;
            raw_q     <= '0;
        end else begin
            if (reg_we) begin
                case (widx)
                    IDX_W'(RG_GCFG):  gen       <= reg_wdata[0];
                    IDX_W'(RG_CHEN):  chen      <= reg_wdata[0];
                    IDX_W'(RG_SRC):   src_init  <= reg_wdata;
                    IDX_W'(RG_FIRST): first_ptr <= reg_wdata;
                    IDX_W'(RG_CFG):   hs_sel    <= reg_wdata[1:0];
                    IDX_W'(RG_MASK):  mask_q    <= reg_wdata[NIRQ-1:0];
                    default: ;
                endcase
            end
            if (chen_clr) chen <= 1'b0;
            raw_q  <= (raw_q & ~clr_bits) | hw_set;
            sw_req <= sw_nxt;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (widx)
            IDX_W'(RG_GCFG):  reg_rdata[0]      = gen;
            IDX_W'(RG_CHEN):  reg_rdata[0]      = chen;
            IDX_W'(RG_SRC):   reg_rdata         = src_init;
            IDX_W'(RG_FIRST): reg_rdata         = first_ptr;
            IDX_W'(RG_CFG):   reg_rdata[1:0]    = hs_sel;
            IDX_W'(RG_SWREQ): reg_rdata[1:0]    = sw_req;
            IDX_W'(RG_MASK):  reg_rdata[NIRQ-1:0] = mask_q;
            IDX_W'(RG_RAW):   reg_rdata[NIRQ-1:0] = raw_q;
            IDX_W'(RG_STAT):  reg_rdata[NIRQ-1:0] = stat;
            default: ;
        endcase
    end

    // R9: a newly raised transfer-done bit is always accompanied by a cleared enable
    a_r9_done_clears_en: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q[IRQ_TFR]) |-> !chen);
    // R11: a newly raised error bit is always accompanied by a cleared enable
    a_r11_err_clears_en: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q[IRQ_ERR]) |-> !chen);
    // R6: software request bits are gone after an acknowledge
    a_r6_sw_autoclear: assert property (@(posedge clk) disable iff (rst)
        sw_clr |=> sw_req == 2'b00);
endmodule

// File: rtl/dmal_seq.sv
module dmal_seq
    import dmal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            chen_i,
    input  logic            gen_i,
    input  logic [AW-1:0]   src_init_i,
    input  logic [AW-1:0]   first_i,
    input  logic            src_rdy,
    input  logic            dst_rdy,
    output logic            ack_o,
    output logic [NIRQ-1:0] hw_set_o,
    output logic            chen_clr_o,
    output logic            int_en_o,
    output logic            m_req,
    output logic            m_we,
    output logic [AW-1:0]   m_addr,
    output logic [DW-1:0]   m_wdata,
    input  logic            m_done,
    input  logic            m_err,
    input  logic [DW-1:0]   m_rdata
);
    seq_st_e          st;
    logic [1:0]       idx;
    logic [AW-1:0]    ptr, nxt, src, dst;
    logic [DW-1:0]    dbuf;
    ctl_word_t        ctl;
    logic [CNT_W-1:0] remaining, beats;
    logic             err_hit, chain_end;

    assign m_req     = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
    assign m_we      = (st == S_WR);
    assign m_addr    = (st == S_FETCH) ? ptr + AW'({idx, 2'b00}) :
                       (st == S_RD)    ? src : dst;
    assign m_wdata   = dbuf;
    assign ack_o     = (st == S_ACK);
    assign err_hit   = m_req && m_done && m_err;
    assign chain_end = (st == S_BEND) && (nxt == '0);
    assign int_en_o  = ctl.int_en;
    assign chen_clr_o = chain_end || err_hit;

    always_comb begin
        hw_set_o          = '0;
        hw_set_o[IRQ_TFR] = chain_end;
        hw_set_o[IRQ_BLK] = (st == S_BEND);
        hw_set_o[IRQ_SRC] = ack_o;
        hw_set_o[IRQ_DST] = ack_o;
        hw_set_o[IRQ_ERR] = err_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; idx <= '0; ptr <= '0; nxt <= '0; src <= '0; dst <= '0;
            dbuf <= '0; ctl <= '0; remaining <= '0; beats <= '0;
        end else begin
            case (st)
                S_IDLE: if (chen_i && gen_i) begin
                    ptr <= first_i; idx <= '0; st <= S_FETCH;
                end
                S_FETCH: if (m_done) begin
                    if (m_err) st <= S_IDLE;
                    else begin
                        idx <= idx + 2'd1;
                        case (idx)
                            2'd1: dst <= m_rdata;
                            2'd2: nxt <= m_rdata;
                            2'd3: begin
                                ctl       <= ctl_word_t'(m_rdata);
                                src       <= src_init_i;
                                remaining <= m_rdata[CNT_W-1:0];
                                st        <= (m_rdata[CNT_W-1:0] == '0) ? S_BEND : S_WAIT;
                            end
                            default: ;
                        endcase
                    end
                end
                S_WAIT: if (src_rdy && dst_rdy) begin
                    beats <= beats_for(ctl.burst, remaining);
                    st    <= S_RD;
                end
                S_RD: if (m_done) begin
                    if (m_err) st <= S_IDLE;
                    else begin dbuf <= m_rdata; st <= S_WR; end
                end
                S_WR: if (m_done) begin
                    if (m_err) st <= S_IDLE;
                    else begin
                        src <= src + AW'(4); dst <= dst + AW'(4);
                        remaining <= remaining - CNT_W'(1);
                        beats     <= beats - CNT_W'(1);
                        st <= (beats == CNT_W'(1)) ? S_ACK : S_RD;
                    end
                end
                S_ACK: st <= (remaining == '0) ? S_BEND : S_WAIT;
                S_BEND: if (nxt == '0) st <= S_IDLE;
                        else begin ptr <= nxt; idx <= '0; st <= S_FETCH; end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5: acknowledge is a single-cycle pulse
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    // R12: an outstanding memory request keeps its address and direction
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
        m_req && !m_done |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));
    // R3: the block's source pointer is the programmed start value
    a_r3_src_reload: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH) && (idx == 2'd3) && m_done && !m_err |=> src == $past(src_init_i));
    // R1: leaving idle requires both enables
    a_r1_start_gate: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH) && ($past(st) == S_IDLE) |-> $past(chen_i) && $past(gen_i));
endmodule

// File: rtl/dma_ll_chan.sv
module dma_ll_chan
    import dmal_pkg::*;
#(
    parameter int RA_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq,
    input  logic            src_req,
    input  logic            dst_req,
    output logic            src_ack,
    output logic            dst_ack,
    output logic            m_req,
    output logic            m_we,
    output logic [31:0]     m_addr,
    output logic [31:0]     m_wdata,
    input  logic            m_done,
    input  logic            m_err,
    input  logic [31:0]     m_rdata
);
    logic            gen, chen, chen_clr, int_en, ack;
    logic [AW-1:0]   src_init, first_ptr;
    logic [1:0]      hs_sel, sw_req, rdy;
    logic [NIRQ-1:0] hw_set;

    assign src_ack = ack;
    assign dst_ack = ack;

    dmal_regs #(.RA_W(RA_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_set(hw_set),
        .chen_clr(chen_clr), .sw_clr(ack), .int_en(int_en), .gen(gen),
        .chen(chen), .src_init(src_init), .first_ptr(first_ptr),
        .hs_sel(hs_sel), .sw_req(sw_req), .irq(irq)
    );

    dmal_hs #(.NSIDE(2)) u_hs (
        .sel(hs_sel), .hw({dst_req, src_req}), .sw(sw_req), .rdy(rdy)
    );

    dmal_seq u_seq (
        .clk(clk), .rst(rst), .chen_i(chen), .gen_i(gen), .src_init_i(src_init),
        .first_i(first_ptr), .src_rdy(rdy[0]), .dst_rdy(rdy[1]), .ack_o(ack),
        .hw_set_o(hw_set), .chen_clr_o(chen_clr), .int_en_o(int_en),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata)
    );
endmodule

// File: tb/test_dma_ll_chan.sv
module test_dma_ll_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, src_ack, dst_ack, m_req, m_we;
    logic        src_req = 1'b1, dst_req = 1'b1;
    logic [31:0] m_addr, m_wdata;
    logic        m_done = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [31:0] mem [256];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int checks = 0, errors = 0, acks = 0, ack_mis = 0, hold_bad = 0, cyc = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    localparam logic [5:0] A_GCFG = 6'h00, A_CHEN = 6'h04, A_SRC = 6'h08, A_FIRST = 6'h0C,
                           A_CFG = 6'h10, A_SWREQ = 6'h14, A_MASK = 6'h18, A_RAW = 6'h1C,
                           A_STAT = 6'h20, A_CLR = 6'h24;
    localparam int NV = 5;
    localparam int VCNT [NV] = '{4, 5, 8, 3, 7};
    localparam int VBL  [NV] = '{1, 2, 4, 0, 8};
    localparam int VACK [NV] = '{4, 3, 2, 3, 1};

    dma_ll_chan i_dma_ll_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .src_req(src_req), .dst_req(dst_req),
        .src_ack(src_ack), .dst_ack(dst_ack), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_ack) acks <= acks + 1;
        if (src_ack != dst_ack) ack_mis <= ack_mis + 1;
        if (pend && !(m_req && m_addr == pend_addr)) hold_bad <= hold_bad + 1;
        pend      <= m_req && !m_done && !rst;
        pend_addr <= m_addr;
        if (rst) begin
            m_done <= 1'b0; m_err <= 1'b0;
        end else if (m_req && !m_done) begin
            m_done  <= 1'b1;
            m_rdata <= mem[m_addr[9:2]];
            m_err   <= (m_addr == err_addr);
            if (m_we && m_addr != err_addr) mem[m_addr[9:2]] <= m_wdata;
        end else begin
            m_done <= 1'b0; m_err <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            rd(A_CHEN, d);
            if (d[0] == 1'b0) return;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_desc(input int at, input logic [31:0] s, input logic [31:0] dd,
                            input logic [31:0] nx, input logic [31:0] ct);
        mem[at/4] = s; mem[at/4+1] = dd; mem[at/4+2] = nx; mem[at/4+3] = ct;
    endtask

    task automatic fill(input int base, input int n, input logic [31:0] seed);
        for (int k = 0; k < n; k++) mem[base/4+k] = seed + 32'(k) * 32'h11;
    endtask

    initial begin
        logic [31:0] d;
        int a0;
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        rd(A_RAW, d);  chk("R10 raw after reset", d, 32'h0);
        rd(A_CHEN, d); chk("R9 enable after reset", d, 32'h0);
        chk("R8 irq after reset", {31'd0, irq}, 32'h0);
        chk("R12 no request after reset", {31'd0, m_req}, 32'h0);

        wr(A_SRC, 32'h100); wr(A_FIRST, 32'h200);
        rd(A_SRC, d);   chk("R13 source readback", d, 32'h100);
        rd(A_FIRST, d); chk("R13 first pointer readback", d, 32'h200);

        // R1: global enable off holds the channel
        fill(32'h100, 8, 32'hA000_0000);
        fill(32'h300, 10, 32'hDEAD_0000);
        put_desc(32'h200, 32'h180, 32'h300, 32'h0, 32'h0000_0002);
        wr(A_CHEN, 32'h1);
        idle(40);
        chk("R1 no move while global enable off", mem[32'h300/4], 32'hDEAD_0000);
        rd(A_CHEN, d); chk("R1 enable stays set", d, 32'h1);
        wr(A_GCFG, 32'h1);
        wait_done();
        chk("R1 block moved after global enable", mem[32'h300/4], 32'hA000_0000);
        wr(A_CLR, 32'h1F);

        // table walk: R4 R5 R7 R9
        for (int v = 0; v < NV; v++) begin
            fill(32'h100, 8, 32'hB000_0000 + 32'(v) * 32'h100);
            fill(32'h300, 10, 32'hDEAD_0000);
            put_desc(32'h200, 32'h180, 32'h300, 32'h0,
                     (32'(VBL[v]) << 16) | 32'(VCNT[v]));
            a0 = acks;
            wr(A_CHEN, 32'h1);
            wait_done();
            for (int k = 0; k < VCNT[v]; k++)
                chk($sformatf("R4 vec%0d word%0d", v, k), mem[32'h300/4 + k],
                    32'hB000_0000 + 32'(v) * 32'h100 + 32'(k) * 32'h11);
            chk($sformatf("R7 vec%0d no write past block", v), mem[32'h300/4 + VCNT[v]],
                32'hDEAD_0000 + 32'(VCNT[v]) * 32'h11);
            chk($sformatf("R5 vec%0d transaction count", v), 32'(acks - a0), 32'(VACK[v]));
            rd(A_RAW, d);
            chk($sformatf("R9 vec%0d raw status", v), d, 32'h0F);
            wr(A_CLR, 32'h1F);
        end
        chk("R5 acks paired", 32'(ack_mis), 32'h0);

        // R10: clear is per bit
        put_desc(32'h200, 32'h180, 32'h300, 32'h0, 32'h0000_0001);
        wr(A_CHEN, 32'h1); wait_done();
        wr(A_CLR, 32'h05);
        rd(A_RAW, d); chk("R10 selective clear", d, 32'h0A);
        wr(A_CLR, 32'h1F);

        // R2 R3: two-block chain, descriptor source ignored, source reloaded
        fill(32'h100, 4, 32'hC000_0000);
        fill(32'h180, 4, 32'hBAD0_0000);
        fill(32'h300, 8, 32'hDEAD_0000);
        fill(32'h340, 8, 32'hDEAD_1000);
        put_desc(32'h200, 32'h180, 32'h300, 32'h220, 32'h0001_0003);
        put_desc(32'h220, 32'h180, 32'h340, 32'h0,   32'h0001_0003);
        wr(A_CHEN, 32'h1); wait_done();
        for (int k = 0; k < 3; k++) begin
            chk("R3 first block data", mem[32'h300/4 + k], 32'hC000_0000 + 32'(k) * 32'h11);
            chk("R2 R3 second block from reloaded source", mem[32'h340/4 + k],
                32'hC000_0000 + 32'(k) * 32'h11);
        end
        rd(A_CHEN, d); chk("R9 enable cleared after chain", d, 32'h0);
        wr(A_CLR, 32'h1F);

        // R8: masking and interrupt enable
        wr(A_MASK, 32'h02);
        put_desc(32'h200, 32'h0, 32'h300, 32'h0, 32'h8001_0002);
        wr(A_CHEN, 32'h1); wait_done();
        rd(A_STAT, d); chk("R8 masked status", d, 32'h02);
        chk("R8 irq on", {31'd0, irq}, 32'h1);
        wr(A_CLR, 32'h02);
        rd(A_STAT, d); chk("R8 status after clear", d, 32'h0);
        chk("R8 irq off after clear", {31'd0, irq}, 32'h0);
        wr(A_CLR, 32'h1F);
        put_desc(32'h200, 32'h0, 32'h300, 32'h0, 32'h0001_0002);
        wr(A_CHEN, 32'h1); wait_done();
        rd(A_RAW, d);  chk("R8 raw block bit without int enable", d & 32'h2, 32'h2);
        rd(A_STAT, d); chk("R8 status gated by int enable", d, 32'h0);
        chk("R8 irq gated by int enable", {31'd0, irq}, 32'h0);
        wr(A_CLR, 32'h1F); wr(A_MASK, 32'h0);

        // R6: software requests
        src_req = 1'b0; dst_req = 1'b0;
        wr(A_CFG, 32'h3);
        fill(32'h100, 4, 32'hE000_0000);
        fill(32'h300, 4, 32'hDEAD_0000);
        put_desc(32'h200, 32'h0, 32'h300, 32'h0, 32'h0001_0002);
        wr(A_CHEN, 32'h1); idle(40);
        chk("R6 no move without software request", mem[32'h300/4], 32'hDEAD_0000);
        wr(A_SWREQ, 32'h1); idle(40);
        chk("R6 one side alone is not enough", mem[32'h300/4], 32'hDEAD_0000);
        wr(A_SWREQ, 32'h2); idle(40);
        chk("R6 first word after both requests", mem[32'h300/4], 32'hE000_0000);
        chk("R6 second word waits", mem[32'h300/4 + 1], 32'hDEAD_0011);
        rd(A_SWREQ, d); chk("R6 software requests self-clear", d, 32'h0);
        wr(A_SWREQ, 32'h3); wait_done();
        chk("R6 second word moved", mem[32'h300/4 + 1], 32'hE000_0011);
        wr(A_CFG, 32'h0); src_req = 1'b1; dst_req = 1'b1;
        wr(A_CLR, 32'h1F);

        // R11: error in a data move
        fill(32'h100, 4, 32'hF000_0000);
        fill(32'h300, 4, 32'hDEAD_0000);
        put_desc(32'h200, 32'h0, 32'h300, 32'h0, 32'h0001_0004);
        err_addr = 32'h104;
        wr(A_CHEN, 32'h1); wait_done(); idle(10);
        rd(A_RAW, d);  chk("R11 error raw status", d & 32'h13, 32'h10);
        rd(A_CHEN, d); chk("R11 enable cleared", d, 32'h0);
        chk("R11 word before error written", mem[32'h300/4], 32'hF000_0000);
        chk("R11 no write after error", mem[32'h300/4 + 1], 32'hDEAD_0011);
        chk("R11 memory port idle", {31'd0, m_req}, 32'h0);
        wr(A_CLR, 32'h1F);
        // R11: error in a descriptor read
        err_addr = 32'h208;
        wr(A_CHEN, 32'h1); wait_done(); idle(10);
        rd(A_RAW, d); chk("R11 fetch error", d, 32'h10);
        err_addr = 32'hFFFF_FFFF;

        chk("R12 request held until done", 32'(hold_bad), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule